// File: doc/BRIEF.md
# Handheld Console Memory Bus Router

This block sits between a byte-wide CPU and every memory target of a handheld console with a fixed 16-bit address map. It decodes each address to one of these targets: the cartridge port, video RAM, work RAM and its mirror, object RAM, high RAM, the I/O register port, or a boot ROM overlay. It also works out the physical address inside that target. The four on-chip RAMs and the boot ROM share a single local memory port, told apart by a select code. The cartridge and I/O ports reuse the CPU address and write data, and they get their own read and write strobes.

Read data is combinational. It returns 0xFF whenever the addressed region is locked, unmapped or blocked. Writes take effect on the rising clock edge. The block holds three registers inside the I/O range: the video bank, the work RAM bank and the sticky boot-overlay disable. Access permission flags and the DMA status come from the graphics unit. While object DMA runs, only a reduced set of regions stays reachable. A peek input reads through the same decode without raising any read strobe.

Top module: `hh_bus_router`

## Requirements
- R1: Addresses 0x0000-0x7FFF that the boot ROM does not cover, and all of 0xA000-0xBFFF, go to the cartridge port. A read there raises cart_rd and returns cart_rdata. A write raises cart_wr.
- R2: 0x8000-0x9FFF is video RAM: mem_sel=2, mem_addr={video bank, addr[12:0]}. If vram_rd_ok is low, reads return 0xFF and mem_rd stays low. If vram_wr_ok is low, writes raise no strobe.
- R3: 0xC000-0xCFFF is work RAM bank 0: mem_sel=3, mem_addr={3'd0, addr[11:0]}. 0xD000-0xDFFF uses the selected bank: mem_addr={bank, addr[11:0]}. A bank value of 0 selects bank 1.
- R4: 0xE000-0xEFFF mirrors work RAM bank 0. 0xF000-0xFDFF mirrors the selected switchable bank. Both use the same mem_sel=3 addressing as R3.
- R5: 0xFE00-0xFE9F is object RAM: mem_sel=4, mem_addr=addr[7:0], gated by oam_rd_ok and oam_wr_ok in the same way as R2. 0xFEA0-0xFEFF is unmapped. Reads there return 0xFF and writes raise no strobe.
- R6: 0xFF80-0xFFFE is high RAM: mem_sel=5, mem_addr=addr[6:0]. 0xFF00-0xFF7F and 0xFFFF go to the I/O port through io_rd and io_wr, except at the three register addresses of R9.
- R7: While the boot disable bit is 0, reads of 0x0000-0x00FF come from the boot ROM: mem_sel=1, mem_addr=addr[11:0]. When color_mode is high, reads of 0x0200-0x08FF also come from the boot ROM. 0x0100-0x01FF and 0x0900 and up always go to the cartridge.
- R8: A write to an address that the boot ROM currently covers raises no strobe. Writing bit 0 as 1 to 0xFF50 sets the boot disable bit. After that, writing 0 does not clear it; only reset does.
- R9: The video bank register sits at 0xFF4F, 1 bit, and reads back as 0xFE|bank. The work bank register sits at 0xFF70, 3 bits, and reads back as 0xF8|bank. The boot disable bit sits at 0xFF50 and reads back as 0xFE|bit. All three reset to 0, and accesses to them never reach the I/O port.
- R10: While dma_active is high, only these regions stay reachable: the work RAM mirror (0xE000-0xFDFF), the I/O range, high RAM, 0xFFFF, and object RAM when dma_oam_ok is high (its normal flags are then ignored). Every other read returns 0xFF and every other write raises no strobe.
- R11: While dma_active is high, a read below 0x8000 returns 0xFF if dma_src_hi is below 0x80. Otherwise it reads the cartridge, bypassing the boot overlay. Cartridge writes raise no strobe during DMA.
- R12: With peek high, rdata shows the same value a read would return. No read strobe is raised on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| color_mode | input | 1 | Enables the extended boot overlay |
| addr | input | 16 | CPU address, also seen by the cartridge and I/O ports |
| rd | input | 1 | CPU read |
| wr | input | 1 | CPU write |
| peek | input | 1 | Debug read without strobes |
| wdata | input | 8 | CPU write data, shared by all targets |
| rdata | output | 8 | Read data |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_rdata | input | 8 | Cartridge read data |
| io_rd | output | 1 | I/O register read strobe |
| io_wr | output | 1 | I/O register write strobe |
| io_rdata | input | 8 | I/O register read data |
| mem_sel | output | 3 | Local memory select: 0 none, 1 boot, 2 video, 3 work, 4 object, 5 high |
| mem_addr | output | 15 | Physical address within the selected memory |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_rdata | input | 8 | Local memory read data |
| vram_rd_ok | input | 1 | Video RAM read permitted |
| vram_wr_ok | input | 1 | Video RAM write permitted |
| oam_rd_ok | input | 1 | Object RAM read permitted |
| oam_wr_ok | input | 1 | Object RAM write permitted |
| dma_active | input | 1 | Object DMA in progress |
| dma_src_hi | input | 8 | High byte of the DMA source address |
| dma_oam_ok | input | 1 | Object RAM reachable during DMA |

## Verification
The decode is tried at the first and last byte of each region and at addresses just past its edges. These show whether each range boundary and each physical address is right. The same addresses are then repeated with a bank register changed, with a permission flag dropped, with color mode on and off, and with the boot bit set. These runs show whether the data comes from the right bank, whether the 0xFF masking applies, and whether a write is dropped or forwarded. A final run under DMA, with a low and a high source byte, tells the reachable regions apart from the blocked ones. Peek is compared against a plain read of the same address.

// File: rtl/hh_bus_router.sv
module hh_bus_router #(
  parameter int VB = 1,
  parameter int WB = 3,
  parameter logic [15:0] VBANK_REG = 16'hFF4F,
  parameter logic [15:0] BOOT_REG  = 16'hFF50,
  parameter logic [15:0] WBANK_REG = 16'hFF70,
  localparam int MA_W = (12 + WB > 13 + VB) ? 12 + WB : 13 + VB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            color_mode,
  input  logic [15:0]     addr,
  input  logic            rd,
  input  logic            wr,
  input  logic            peek,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            cart_rd,
  output logic            cart_wr,
  input  logic [7:0]      cart_rdata,
  output logic            io_rd,
  output logic            io_wr,
  input  logic [7:0]      io_rdata,
  output logic [2:0]      mem_sel,
  output logic [MA_W-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  input  logic [7:0]      mem_rdata,
  input  logic            vram_rd_ok,
  input  logic            vram_wr_ok,
  input  logic            oam_rd_ok,
  input  logic            oam_wr_ok,
  input  logic            dma_active,
  input  logic [7:0]      dma_src_hi,
  input  logic            dma_oam_ok
);
  localparam logic [3:0] T_NONE = 4'd0, T_BOOT = 4'd1, T_VID = 4'd2, T_WORK = 4'd3,
                         T_OBJ = 4'd4, T_HIGH = 4'd5, T_CART = 4'd6, T_IO = 4'd7,
                         T_REG = 4'd8;

  logic [VB-1:0] vbank;
  logic [WB-1:0] wbank;
  logic          boot_off;
  logic [3:0]    tgt;
  logic          rok, wok;
  logic [7:0]    reg_rdata;

  wire [WB-1:0] wsel    = (wbank == '0) ? WB'(1) : wbank;
  wire          in_io   = (addr[15:7] == 9'h1FE) || (addr == 16'hFFFF);
  wire          in_high = (addr[15:7] == 9'h1FF) && (addr != 16'hFFFF);
  wire          in_obj  = (addr >= 16'hFE00) && (addr < 16'hFEA0);
  wire          in_echo = (addr >= 16'hE000) && (addr < 16'hFE00);
  wire          overlay = !boot_off && ((addr < 16'h0100) ||
                          (color_mode && addr >= 16'h0200 && addr < 16'h0900));
  wire          is_reg  = (addr == VBANK_REG) || (addr == BOOT_REG) || (addr == WBANK_REG);

  always_comb begin
    tgt = T_NONE;
    rok = 1'b0;
    wok = 1'b0;
    if (dma_active) begin
      if (addr < 16'h8000) begin
        if (dma_src_hi >= 8'h80) begin
          tgt = T_CART;
          rok = 1'b1;
        end
      end else if (in_echo) begin
        tgt = T_WORK; rok = 1'b1; wok = 1'b1;
      end else if (in_obj) begin
        if (dma_oam_ok) begin
          tgt = T_OBJ; rok = 1'b1; wok = 1'b1;
        end
      end else if (in_io) begin
        tgt = T_IO; rok = 1'b1; wok = 1'b1;
      end else if (in_high) begin
        tgt = T_HIGH; rok = 1'b1; wok = 1'b1;
      end
    end else begin
      if (addr < 16'h8000) begin
        if (overlay) begin
          tgt = T_BOOT; rok = 1'b1;
        end else begin
          tgt = T_CART; rok = 1'b1; wok = 1'b1;
        end
      end else if (addr < 16'hA000) begin
        tgt = T_VID; rok = vram_rd_ok; wok = vram_wr_ok;
      end else if (addr < 16'hC000) begin
        tgt = T_CART; rok = 1'b1; wok = 1'b1;
      end else if (addr < 16'hFE00) begin
        tgt = T_WORK; rok = 1'b1; wok = 1'b1;
      end else if (in_obj) begin
        tgt = T_OBJ; rok = oam_rd_ok; wok = oam_wr_ok;
      end else if (in_io) begin
        tgt = T_IO; rok = 1'b1; wok = 1'b1;
      end else if (in_high) begin
        tgt = T_HIGH; rok = 1'b1; wok = 1'b1;
      end
    end
    if (tgt == T_IO && is_reg) tgt = T_REG;
  end

  always_comb begin
    case (tgt)
      T_BOOT:  mem_addr = MA_W'(addr[11:0]);
      T_VID:   mem_addr = MA_W'({vbank, addr[12:0]});
      T_WORK:  mem_addr = MA_W'({addr[12] ? wsel : {WB{1'b0}}, addr[11:0]});
      T_OBJ:   mem_addr = MA_W'(addr[7:0]);
      T_HIGH:  mem_addr = MA_W'(addr[6:0]);
      default: mem_addr = '0;
    endcase
  end

  assign mem_sel = (tgt <= T_HIGH) ? tgt[2:0] : 3'd0;
  wire   is_mem  = (mem_sel != 3'd0);
  wire   act_rd  = rd && !peek;

  assign cart_rd = act_rd && rok && tgt == T_CART;
  assign cart_wr = wr && wok && tgt == T_CART;
  assign io_rd   = act_rd && rok && tgt == T_IO;
  assign io_wr   = wr && wok && tgt == T_IO;
  assign mem_rd  = act_rd && rok && is_mem;
  assign mem_wr  = wr && wok && is_mem;

  always_comb begin
    if (addr == VBANK_REG)      reg_rdata = {{(8-VB){1'b1}}, vbank};
    else if (addr == WBANK_REG) reg_rdata = {{(8-WB){1'b1}}, wbank};
    else                        reg_rdata = {7'h7F, boot_off};
  end

  always_comb begin
    if (!rok)                rdata = 8'hFF;
    else if (tgt == T_CART)  rdata = cart_rdata;
    else if (tgt == T_IO)    rdata = io_rdata;
    else if (tgt == T_REG)   rdata = reg_rdata;
    else if (is_mem)         rdata = mem_rdata;
    else                     rdata = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbank    <= '0;
      wbank    <= '0;
      boot_off <= 1'b0;
    end else if (wr && wok && tgt == T_REG) begin
      if (addr == VBANK_REG)      vbank    <= wdata[VB-1:0];
      else if (addr == WBANK_REG) wbank    <= wdata[WB-1:0];
      else                        boot_off <= boot_off | wdata[0];
    end
  end
endmodule

// File: rtl/hh_bus_router_chk.sv
module hh_bus_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        peek,
  input logic [7:0]  rdata,
  input logic        cart_rd,
  input logic        cart_wr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [2:0]  mem_sel,
  input logic        vram_rd_ok,
  input logic        dma_active,
  input logic        boot_off
);
  p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hFEA0 && addr < 16'hFF00) |-> (rdata == 8'hFF && !cart_wr && !io_wr && !mem_wr));

  p_vram_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_active && addr >= 16'h8000 && addr < 16'hA000 && !vram_rd_ok) |-> (rdata == 8'hFF && !mem_rd));

  p_boot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_off) |-> boot_off);

  p_boot_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel == 3'd1) |-> !mem_wr);

  p_dma_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && addr >= 16'h8000 && addr < 16'hE000) |-> (rdata == 8'hFF && !mem_wr && !cart_wr));

  p_dma_cart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> !cart_wr);

  p_peek_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    peek |-> (!cart_rd && !io_rd && !mem_rd));
endmodule

bind hh_bus_router hh_bus_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .peek(peek), .rdata(rdata),
  .cart_rd(cart_rd), .cart_wr(cart_wr), .io_rd(io_rd), .io_wr(io_wr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sel(mem_sel),
  .vram_rd_ok(vram_rd_ok), .dma_active(dma_active), .boot_off(boot_off)
);

// File: tb/hh_bus_router_test.sv
module hh_bus_router_test;
  localparam int PERIOD = 10;
  localparam int RD = 0, WR = 1, PK = 2;
  localparam int KN = 0, KC = 1, KI = 2, KM = 3, KR = 4;

  logic clk = 0, rst_n = 0, color_mode = 0;
  logic [15:0] addr = 0;
  logic rd = 0, wr = 0, peek = 0;
  logic [7:0] wdata = 0, rdata, cart_rdata, io_rdata, mem_rdata;
  logic cart_rd, cart_wr, io_rd, io_wr, mem_rd, mem_wr;
  logic [2:0] mem_sel;
  logic [14:0] mem_addr;
  logic vram_rd_ok = 1, vram_wr_ok = 1, oam_rd_ok = 1, oam_wr_ok = 1;
  logic dma_active = 0, dma_oam_ok = 0;
  logic [7:0] dma_src_hi = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    int op; int kind;
    logic [7:0] data; logic [2:0] sel; logic [14:0] ma; string tag;
  } exp_t;
  exp_t q[$];
  event go;

  always #(PERIOD/2) clk = ~clk;

  assign cart_rdata = addr[7:0] ^ 8'h5A;
  assign io_rdata   = addr[7:0] ^ 8'hC3;
  assign mem_rdata  = mem_addr[7:0] ^ {mem_sel, 5'd0};

  hh_bus_router uut (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .addr(addr), .rd(rd), .wr(wr),
    .peek(peek), .wdata(wdata), .rdata(rdata), .cart_rd(cart_rd), .cart_wr(cart_wr),
    .cart_rdata(cart_rdata), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .vram_rd_ok(vram_rd_ok), .vram_wr_ok(vram_wr_ok),
    .oam_rd_ok(oam_rd_ok), .oam_wr_ok(oam_wr_ok), .dma_active(dma_active),
    .dma_src_hi(dma_src_hi), .dma_oam_ok(dma_oam_ok)
  );

  task automatic chk(input logic [15:0] a, input int op, input logic [7:0] d,
                     input int kind, input logic [2:0] sel, input logic [14:0] ma,
                     input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; rd = (op == RD); wr = (op == WR); peek = (op == PK); wdata = d;
    e.op = op; e.kind = kind; e.sel = sel; e.ma = ma; e.tag = tag;
    case (kind)
      KC: e.data = a[7:0] ^ 8'h5A;
      KI: e.data = a[7:0] ^ 8'hC3;
      KM: e.data = ma[7:0] ^ {sel, 5'd0};
      KR: e.data = d;
      default: e.data = 8'hFF;
    endcase
    q.push_back(e);
    -> go;
    @(posedge clk);
    #1 rd = 0; wr = 0; peek = 0;
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      logic [5:0] got_s, exp_s;
      @(go);
      #1;
      e = q.pop_front();
      checks++;
      exp_s = {e.op == RD && e.kind == KC, e.op == WR && e.kind == KC,
               e.op == RD && e.kind == KI, e.op == WR && e.kind == KI,
               e.op == RD && e.kind == KM, e.op == WR && e.kind == KM};
      got_s = {cart_rd, cart_wr, io_rd, io_wr, mem_rd, mem_wr};
      if (got_s !== exp_s ||
          (e.op != WR && rdata !== e.data) ||
          (e.kind == KM && (mem_sel !== e.sel || mem_addr !== e.ma))) begin
        fails++;
        $display("FAIL %s addr=%h: strobes %b exp %b, rdata %h exp %h, sel %0d exp %0d, maddr %h exp %h",
                 e.tag, addr, got_s, exp_s, rdata, e.data, mem_sel, e.sel, mem_addr, e.ma);
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state R9, R7
    chk(16'h0000, RD, 8'h00, KM, 3'd1, 15'h0000, "R7 reset boot read");
    chk(16'hFF70, RD, 8'hF8, KR, 0, 0, "R9 wbank reset");
    chk(16'hFF4F, RD, 8'hFE, KR, 0, 0, "R9 vbank reset");
    chk(16'hFF50, RD, 8'hFE, KR, 0, 0, "R9 boot bit reset");
    // R7 overlay shape
    chk(16'h0050, RD, 8'h00, KM, 3'd1, 15'h0050, "R7 low overlay");
    chk(16'h0150, RD, 8'h00, KC, 0, 0, "R7 header hole");
    chk(16'h0300, RD, 8'h00, KC, 0, 0, "R7 mono upper");
    color_mode = 1;
    chk(16'h0300, RD, 8'h00, KM, 3'd1, 15'h0300, "R7 color upper");
    chk(16'h08FF, RD, 8'h00, KM, 3'd1, 15'h08FF, "R7 color top");
    chk(16'h0900, RD, 8'h00, KC, 0, 0, "R7 past overlay");
    chk(16'h01FF, RD, 8'h00, KC, 0, 0, "R7 color hole");
    chk(16'h0010, PK, 8'h00, KM, 3'd1, 15'h0010, "R12 peek boot");
    // R8 overlay writes dropped
    chk(16'h0010, WR, 8'h33, KN, 0, 0, "R8 write low overlay");
    chk(16'h0300, WR, 8'h33, KN, 0, 0, "R8 write color overlay");
    chk(16'h0150, WR, 8'h33, KC, 0, 0, "R8 write hole");
    // R1 cartridge
    chk(16'h4000, RD, 8'h00, KC, 0, 0, "R1 rom read");
    chk(16'h7FFF, RD, 8'h00, KC, 0, 0, "R1 rom top");
    chk(16'hA123, RD, 8'h00, KC, 0, 0, "R1 ram read");
    chk(16'hBFFF, WR, 8'h12, KC, 0, 0, "R1 ram write");
    // R2 video
    chk(16'h8123, RD, 8'h00, KM, 3'd2, 15'h0123, "R2 vram bank0");
    chk(16'hFF4F, WR, 8'h01, KR, 0, 0, "R9 vbank write");
    chk(16'hFF4F, RD, 8'hFF, KR, 0, 0, "R9 vbank readback");
    chk(16'h9FFF, RD, 8'h00, KM, 3'd2, 15'h3FFF, "R2 vram bank1");
    vram_rd_ok = 0;
    chk(16'h8123, RD, 8'h00, KN, 0, 0, "R2 vram read locked");
    chk(16'h8123, WR, 8'h44, KM, 3'd2, 15'h2123, "R2 vram write open");
    vram_wr_ok = 0; vram_rd_ok = 1;
    chk(16'h8123, WR, 8'h44, KN, 0, 0, "R2 vram write locked");
    vram_wr_ok = 1;
    // R3 work
    chk(16'hC010, RD, 8'h00, KM, 3'd3, 15'h0010, "R3 bank0");
    chk(16'hD010, RD, 8'h00, KM, 3'd3, 15'h1010, "R3 bank zero picks 1");
    chk(16'hFF70, WR, 8'h05, KR, 0, 0, "R9 wbank write");
    chk(16'hFF70, RD, 8'hFD, KR, 0, 0, "R9 wbank readback");
    chk(16'hD010, RD, 8'h00, KM, 3'd3, 15'h5010, "R3 bank5");
    chk(16'hDFFF, WR, 8'h77, KM, 3'd3, 15'h5FFF, "R3 bank5 write");
    // R4 echo
    chk(16'hE010, RD, 8'h00, KM, 3'd3, 15'h0010, "R4 echo low");
    chk(16'hF010, RD, 8'h00, KM, 3'd3, 15'h5010, "R4 echo banked");
    chk(16'hFDFF, WR, 8'h66, KM, 3'd3, 15'h5DFF, "R4 echo top write");
    // R5 object / unmapped
    chk(16'hFE10, RD, 8'h00, KM, 3'd4, 15'h0010, "R5 oam read");
    chk(16'hFE9F, WR, 8'h11, KM, 3'd4, 15'h009F, "R5 oam write");
    oam_rd_ok = 0; oam_wr_ok = 0;
    chk(16'hFE10, RD, 8'h00, KN, 0, 0, "R5 oam read locked");
    chk(16'hFE10, WR, 8'h11, KN, 0, 0, "R5 oam write locked");
    oam_rd_ok = 1; oam_wr_ok = 1;
    chk(16'hFEA0, RD, 8'h00, KN, 0, 0, "R5 unmapped read");
    chk(16'hFEFF, WR, 8'h22, KN, 0, 0, "R5 unmapped write");
    // R6 high / io
    chk(16'hFF80, RD, 8'h00, KM, 3'd5, 15'h0000, "R6 hram low");
    chk(16'hFFFE, WR, 8'h9A, KM, 3'd5, 15'h007E, "R6 hram top");
    chk(16'hFF00, RD, 8'h00, KI, 0, 0, "R6 io low");
    chk(16'hFF7F, WR, 8'h01, KI, 0, 0, "R6 io top write");
    chk(16'hFFFF, RD, 8'h00, KI, 0, 0, "R6 io ffff");
    // R8 sticky disable
    chk(16'hFF50, WR, 8'h01, KR, 0, 0, "R8 boot disable");
    chk(16'h0010, RD, 8'h00, KC, 0, 0, "R8 overlay gone");
    chk(16'h0300, RD, 8'h00, KC, 0, 0, "R8 color overlay gone");
    chk(16'hFF50, WR, 8'h00, KR, 0, 0, "R8 clear attempt");
    chk(16'hFF50, RD, 8'hFF, KR, 0, 0, "R8 sticky readback");
    chk(16'h0010, WR, 8'h55, KC, 0, 0, "R8 write after disable");
    // R12 peek
    chk(16'h4000, PK, 8'h00, KC, 0, 0, "R12 peek cart");
    chk(16'hFF10, PK, 8'h00, KI, 0, 0, "R12 peek io");
    chk(16'hC020, PK, 8'h00, KM, 3'd3, 15'h0020, "R12 peek work");
    // R10/R11 DMA
    dma_active = 1; dma_src_hi = 8'h40;
    chk(16'h1000, RD, 8'h00, KN, 0, 0, "R11 dma low src");
    dma_src_hi = 8'hC0;
    chk(16'h1000, RD, 8'h00, KC, 0, 0, "R11 dma high src");
    chk(16'h1000, WR, 8'h01, KN, 0, 0, "R11 dma cart write");
    chk(16'hA000, WR, 8'h01, KN, 0, 0, "R10 dma ext ram write");
    chk(16'hA000, RD, 8'h00, KN, 0, 0, "R10 dma ext ram read");
    chk(16'h8000, RD, 8'h00, KN, 0, 0, "R10 dma vram");
    chk(16'hC010, RD, 8'h00, KN, 0, 0, "R10 dma work");
    chk(16'hE010, RD, 8'h00, KM, 3'd3, 15'h0010, "R10 dma echo");
    chk(16'hF010, WR, 8'h08, KM, 3'd3, 15'h5010, "R10 dma echo write");
    chk(16'hFE10, RD, 8'h00, KN, 0, 0, "R10 dma oam off");
    dma_oam_ok = 1; oam_rd_ok = 0;
    chk(16'hFE10, RD, 8'h00, KM, 3'd4, 15'h0010, "R10 dma oam on");
    chk(16'hFF10, RD, 8'h00, KI, 0, 0, "R10 dma io");
    chk(16'hFF70, RD, 8'hFD, KR, 0, 0, "R10 dma reg");
    chk(16'hFF90, RD, 8'h00, KM, 3'd5, 15'h0010, "R10 dma hram");
    chk(16'hFFFF, WR, 8'h1F, KI, 0, 0, "R10 dma ffff");
    dma_active = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule